// File: doc/BRIEF.md
# Watchdog Timer with Alternating Two-Step Clear

This block is a watchdog for a small processor core. It counts ticks of a slow time source, qualified by a clock-enable input, and if software stops servicing it before the selected timeout it either asks the reset sequencer to reset the core or, when the core is idle or asleep, wakes the core and marks the event in two status flags: a time-out flag and a power-down flag.

Software services the watchdog in one of two ways. It can issue a single clear command. It can also use a two-step clear made of two distinct commands, the first half and the second half. A half is accepted only when it alternates with the other half, so a runaway loop that keeps repeating one command never keeps the watchdog quiet. A small control register holds an enable bit and a 3-bit period field. Clear commands reach the block as one-cycle strobes from the instruction decoder.

Top module: `wdt_paired_clear`

## Requirements
- R1: After the synchronous reset, rst_req, wake_req, flag_to and flag_pdf are all 0.
- R2: With period field value p (ctl_wdata bits 2:0), overflow occurs on the 2^(8+p)-th clock edge with tick_en high after the counter was zeroed; edges with tick_en low do not count.
- R3: An overflow while core_asleep is 0 drives rst_req high for exactly 4 cycles starting the cycle after the overflow edge, sets flag_to to 1, leaves flag_pdf unchanged and restarts the count from zero.
- R4: An overflow while core_asleep is 1 sets flag_to and flag_pdf to 1, drives wake_req high for exactly one cycle and leaves rst_req low.
- R5: A clr_single strobe zeroes the counter and clears flag_to and flag_pdf at the same edge.
- R6: The tracker starts by expecting the first half; an accepted clr_first makes it expect clr_second and an accepted clr_second makes it expect clr_first. Each accepted half zeroes the counter and clears flag_to and flag_pdf.
- R7: A half that is not the expected one has no effect, so the same half twice in a row, a second half with no first half before it, and both halves strobed in the same cycle are all ignored.
- R8: A clr_single strobe and any overflow both return the tracker to expecting the first half.
- R9: A write with ctl_wdata bit 3 at 0 disables the watchdog: the counter holds at zero and no overflow occurs; bit 3 at 1 enables it. After reset the watchdog is enabled with period field 7.
- R10: A control write whose value differs from the stored one restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Clock enable marking one timeout tick |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 4 | Control value: bit 3 enable, bits 2:0 period field |
| core_asleep | input | 1 | Core is in an idle or sleep state |
| clr_single | input | 1 | Single clear command strobe |
| clr_first | input | 1 | First half of the two-step clear |
| clr_second | input | 1 | Second half of the two-step clear |
| rst_req | output | 1 | Reset request to the reset sequencer |
| wake_req | output | 1 | Wake request pulse to the core |
| flag_to | output | 1 | Time-out status flag |
| flag_pdf | output | 1 | Power-down status flag |

## Verification
The clear scheme is tried with correct alternation, a repeated first half, a second half issued straight after an overflow, both halves in one cycle and a second half issued after a single clear; because every timing check counts the exact edge of the overflow, a wrongly accepted half shows up as an overflow one or more cycles late. Overflow is exercised awake and asleep, which separates the reset path from the wake path and the behaviour of the two flags. Period selection, mid-count period change, the disable bit and a half-rate tick pattern separate tick counting from clock counting and restart from carry-on.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int SEL_W   = 3;
    localparam int MAX_SEL = (1 << SEL_W) - 1;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } wdt_ctl_t;

    localparam int CTL_W = $bits(wdt_ctl_t);

    localparam wdt_ctl_t CTL_RESET = '{en: 1'b1, sel: {SEL_W{1'b1}}};

    typedef enum logic {
        EXPECT_FIRST  = 1'b0,
        EXPECT_SECOND = 1'b1
    } pair_phase_e;

endpackage

// File: rtl/wdt_pair_gate.sv
module wdt_pair_gate
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_single,
    input  logic clr_first,
    input  logic clr_second,
    input  logic overflow,
    output logic clear_ok
);

    pair_phase_e phase;
    logic        first_ok;
    logic        second_ok;

    always_comb begin
        first_ok  = clr_first  && !clr_second && (phase == EXPECT_FIRST);
        second_ok = clr_second && !clr_first  && (phase == EXPECT_SECOND);
        clear_ok  = clr_single || first_ok || second_ok;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_single || overflow) begin
            phase <= EXPECT_FIRST;
        end else if (first_ok) begin
            phase <= EXPECT_SECOND;
        end else if (second_ok) begin
            phase <= EXPECT_FIRST;
        end
    end

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 8,
    localparam int CNT_W   = BASE_EXP + MAX_SEL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    input  logic             clear,
    output logic             overflow
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] terminal;
    logic             hit;

    always_comb begin
        terminal = {CNT_W{1'b1}} >> (~sel);
        hit      = enable && tick_en && (cnt == terminal);
        overflow = hit && !clear && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable || clear || restart || hit) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_status.sv
module wdt_status #(
    parameter int RST_HOLD = 4,
    localparam int HOLD_W  = $clog2(RST_HOLD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic overflow,
    input  logic asleep,
    input  logic clear_ok,
    output logic rst_req,
    output logic wake_req,
    output logic flag_to,
    output logic flag_pdf
);

    logic [HOLD_W-1:0] hold;

    assign rst_req = (hold != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            wake_req <= 1'b0;
            flag_to  <= 1'b0;
            flag_pdf <= 1'b0;
        end else begin
            wake_req <= overflow && asleep;
            if (overflow) begin
                flag_to <= 1'b1;
                if (asleep) begin
                    flag_pdf <= 1'b1;
                end else begin
                    hold <= HOLD_W'(RST_HOLD);
                end
            end else begin
                if (clear_ok) begin
                    flag_to  <= 1'b0;
                    flag_pdf <= 1'b0;
                end
                if (hold != '0) begin
                    hold <= hold - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdt_paired_clear.sv
module wdt_paired_clear
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 8,
    parameter int RST_HOLD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             core_asleep,
    input  logic             clr_single,
    input  logic             clr_first,
    input  logic             clr_second,
    output logic             rst_req,
    output logic             wake_req,
    output logic             flag_to,
    output logic             flag_pdf
);

    wdt_ctl_t ctl;
    logic     restart;
    logic     overflow;
    logic     clear_ok;

    assign restart = ctl_wr && (ctl_wdata != {ctl.en, ctl.sel});

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CTL_RESET;
        end else if (ctl_wr) begin
            ctl <= wdt_ctl_t'(ctl_wdata);
        end
    end

    wdt_pair_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .clr_single (clr_single),
        .clr_first  (clr_first),
        .clr_second (clr_second),
        .overflow   (overflow),
        .clear_ok   (clear_ok)
    );

    wdt_tick_counter #(.BASE_EXP(BASE_EXP)) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .enable   (ctl.en),
        .sel      (ctl.sel),
        .restart  (restart),
        .clear    (clear_ok),
        .overflow (overflow)
    );

    wdt_status #(.RST_HOLD(RST_HOLD)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .overflow (overflow),
        .asleep   (core_asleep),
        .clear_ok (clear_ok),
        .rst_req  (rst_req),
        .wake_req (wake_req),
        .flag_to  (flag_to),
        .flag_pdf (flag_pdf)
    );

endmodule

// File: rtl/wdt_paired_clear_chk.sv
module wdt_paired_clear_chk #(
    parameter int RST_HOLD = 4,
    localparam int HI_W    = $clog2(RST_HOLD + 2)
) (
    input logic clk,
    input logic rst,
    input logic clr_single,
    input logic rst_req,
    input logic wake_req,
    input logic flag_to,
    input logic flag_pdf
);

    logic [HI_W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !rst_req) begin
            hi_cnt <= '0;
        end else if (hi_cnt != {HI_W{1'b1}}) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R3: reset request never outlives its hold window
    a_r3_hold_bound: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (hi_cnt < HI_W'(RST_HOLD)));

    // R3: reset request falls only after the full hold window
    a_r3_hold_full: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req) |-> (hi_cnt == HI_W'(RST_HOLD)));

    // R3: a rising reset request comes with the time-out flag
    a_r3_to_set: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> flag_to);

    // R4: a wake carries both flags and no reset request
    a_r4_wake_flags: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (flag_to && flag_pdf && !rst_req));

    // R4: wake request lasts one cycle
    a_r4_wake_pulse: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req);

    // R5: single clear drops both flags
    a_r5_single_clears: assert property (@(posedge clk) disable iff (rst)
        clr_single |=> (!flag_to && !flag_pdf));

endmodule

bind wdt_paired_clear wdt_paired_clear_chk #(.RST_HOLD(RST_HOLD)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_single (clr_single),
    .rst_req    (rst_req),
    .wake_req   (wake_req),
    .flag_to    (flag_to),
    .flag_pdf   (flag_pdf)
);

// File: tb/tb_wdt_paired_clear.sv
module tb_wdt_paired_clear;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [3:0] ctl_wdata = 4'h0;
    logic       core_asleep = 1'b0;
    logic       clr_single = 1'b0;
    logic       clr_first = 1'b0;
    logic       clr_second = 1'b0;
    logic       rst_req;
    logic       wake_req;
    logic       flag_to;
    logic       flag_pdf;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_paired_clear dut (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .core_asleep (core_asleep),
        .clr_single  (clr_single),
        .clr_first   (clr_first),
        .clr_second  (clr_second),
        .rst_req     (rst_req),
        .wake_req    (wake_req),
        .flag_to     (flag_to),
        .flag_pdf    (flag_pdf)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic go(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic en, input logic [2:0] sel);
        ctl_wr    = 1'b1;
        ctl_wdata = {en, sel};
        go(1);
        ctl_wr    = 1'b0;
    endtask

    // code bits: [2] single, [1] first, [0] second
    task automatic strobe(input logic [2:0] code);
        {clr_single, clr_first, clr_second} = code;
        go(1);
        {clr_single, clr_first, clr_second} = 3'b000;
    endtask

    task automatic t_reset;
        chk("R1", "rst_req", rst_req, 1'b0);
        chk("R1", "wake_req", wake_req, 1'b0);
        chk("R1", "flag_to", flag_to, 1'b0);
        chk("R1", "flag_pdf", flag_pdf, 1'b0);
    endtask

    task automatic t_run_overflow;
        tick_en = 1'b1;
        wr_ctl(1'b1, 3'd0);
        go(255);
        chk("R2", "rst_req before 256 ticks", rst_req, 1'b0);
        go(1);
        chk("R2", "rst_req at 256 ticks", rst_req, 1'b1);
        chk("R3", "flag_to after run overflow", flag_to, 1'b1);
        chk("R3", "flag_pdf after run overflow", flag_pdf, 1'b0);
        chk("R3", "wake_req after run overflow", wake_req, 1'b0);
        go(3);
        chk("R3", "rst_req in 4th cycle", rst_req, 1'b1);
        go(1);
        chk("R3", "rst_req after 4 cycles", rst_req, 1'b0);
    endtask

    task automatic t_single;
        strobe(3'b100);
        chk("R5", "flag_to after single clear", flag_to, 1'b0);
        go(255);
        chk("R5", "no overflow 255 after clear", rst_req, 1'b0);
        go(1);
        chk("R5", "overflow 256 after clear", rst_req, 1'b1);
        go(4);
    endtask

    task automatic t_sleep;
        core_asleep = 1'b1;
        strobe(3'b100);
        go(255);
        chk("R4", "wake_req early", wake_req, 1'b0);
        go(1);
        chk("R4", "wake_req at overflow", wake_req, 1'b1);
        chk("R4", "flag_to asleep", flag_to, 1'b1);
        chk("R4", "flag_pdf asleep", flag_pdf, 1'b1);
        chk("R4", "rst_req asleep", rst_req, 1'b0);
        go(1);
        chk("R4", "wake_req one cycle", wake_req, 1'b0);
        chk("R4", "flag_pdf held", flag_pdf, 1'b1);
    endtask

    task automatic t_pair;
        strobe(3'b010);
        chk("R6", "flag_to after first half", flag_to, 1'b0);
        chk("R6", "flag_pdf after first half", flag_pdf, 1'b0);
        go(99);
        strobe(3'b001);
        go(255);
        chk("R6", "second half zeroed count (early)", wake_req, 1'b0);
        go(1);
        chk("R6", "second half zeroed count (overflow)", wake_req, 1'b1);
        go(1);
        // R8: overflow returned the tracker to expecting the first half
        strobe(3'b001);
        chk("R8", "second half after overflow ignored", flag_to, 1'b1);
        chk("R7", "pdf kept by ignored half", flag_pdf, 1'b1);
        strobe(3'b010);
        chk("R6", "first half accepted", flag_to, 1'b0);
        strobe(3'b010);
        go(254);
        chk("R7", "repeated first half ignored (early)", wake_req, 1'b0);
        go(1);
        chk("R7", "repeated first half ignored (overflow)", wake_req, 1'b1);
        go(1);
        strobe(3'b011);
        chk("R7", "both halves together ignored", flag_to, 1'b1);
    endtask

    task automatic t_tracker_reset;
        strobe(3'b010);
        chk("R6", "first half before single", flag_to, 1'b0);
        strobe(3'b100);
        go(49);
        strobe(3'b001);
        go(205);
        chk("R8", "second after single ignored (early)", wake_req, 1'b0);
        go(1);
        chk("R8", "second after single ignored (overflow)", wake_req, 1'b1);
        go(1);
        core_asleep = 1'b0;
    endtask

    task automatic t_disable;
        wr_ctl(1'b0, 3'd0);
        go(600);
        chk("R9", "no reset while disabled", rst_req, 1'b0);
        chk("R9", "no wake while disabled", wake_req, 1'b0);
    endtask

    task automatic t_period;
        wr_ctl(1'b1, 3'd1);
        go(511);
        chk("R2", "period 1 early", rst_req, 1'b0);
        go(1);
        chk("R2", "period 1 at 512 ticks", rst_req, 1'b1);
        go(4);
        go(100);
        wr_ctl(1'b1, 3'd0);
        go(255);
        chk("R10", "period change restarts (early)", rst_req, 1'b0);
        go(1);
        chk("R10", "period change restarts (overflow)", rst_req, 1'b1);
        go(4);
    endtask

    task automatic t_tick_gate;
        strobe(3'b100);
        for (int i = 0; i < 255; i++) begin
            tick_en = 1'b1;
            go(1);
            tick_en = 1'b0;
            go(1);
        end
        chk("R2", "255 ticks over 510 cycles", rst_req, 1'b0);
        tick_en = 1'b1;
        go(1);
        chk("R2", "256th tick overflows", rst_req, 1'b1);
        go(4);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        go(3);
        rst = 1'b0;
        go(1);
        t_reset();
        t_run_overflow();
        t_single();
        t_sleep();
        t_pair();
        t_tracker_reset();
        t_disable();
        t_period();
        t_tick_gate();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule